// File: doc/BRIEF.md
# Cascadable Timer/Event Counter Pair

This block holds two 8-bit modulo counters. Each counter advances on a clock source picked by its control register. The source can be one of the system-clock prescaler strobes, the synchronized rising edge of an external event pin, or, for the second counter, the output of the first. When a counter's value equals its modulo register on an advance, the counter returns to zero, its toggle flop flips and a one-cycle interrupt request pulse follows. Each toggle flop can drive a pin when the output enable of its channel is set. The toggle flop of channel 0 is also exported as a shift clock for a serial port.

A mode bit joins the two channels into one 16-bit counter. Channel 0 is the low byte and channel 1 the high byte, and the pair is clocked from channel 0's source. A match needs both bytes equal at the same time, and then both bytes clear together. Software programs the block through a simple write port and can read either count at any time.

Top module: `tmr_pair`

## Requirements
- R1: After reset both counts, both toggle flops, both interrupt pulses, both pin enables and both pin values are 0.
- R2: In 8-bit mode, each enabled advance of a channel increments its count, unless the count equals the modulo value. In that case the count goes to 0 and the toggle flop flips in the same cycle, and the channel's irq_pulse bit is high for the next cycle. Register map: address 0 is the channel 0 modulo, 1 the channel 1 modulo, 2 the channel 0 control, 3 the channel 1 control and 4 the mode register. A control byte holds the clock code in bits [2:0], run in bit 3, start in bit 4 and output enable in bit 5. A write takes effect from the following cycle.
- R3: Channel 0 clock codes: 0 selects the event edge, and 1 to 5 select presc_tick[0] to presc_tick[4] (divide by 4, 16, 64, 256 and 1024). Codes 6 and 7 select no clock.
- R4: Channel 1 clock codes: 0 selects the event edge and 1 selects the rising edge of channel 0's toggle flop. Codes 2 to 6 select presc_tick[0], [2], [3], [4] and [5] (divide by 4, 64, 256, 1024 and 4096). Code 7 selects no clock.
- R5: event_in passes through two synchronizer flops. One rising edge produces one advance, three clock edges after the pin is sampled high.
- R6: With a modulo value of 0, every enabled advance is a match, so the count stays 0 and an interrupt pulse follows each advance.
- R7: With mode bit 0 set, the pair counts as {count1,count0} on channel 0's source and run bit. A match needs both bytes equal to their modulo values. It clears both bytes, flips channel 0's toggle flop and pulses irq_pulse[0]. irq_pulse[1] stays 0 and channel 1's toggle flop holds.
- R8: pin_en[i] follows the channel's output-enable bit. pin_out[i] equals that channel's toggle flop while it is enabled and is 0 otherwise.
- R9: A control write with the start bit set clears that channel's count; in 16-bit mode a start on channel 0 clears both bytes. The toggle flops keep their value.
- R10: sclk_out always equals channel 0's toggle flop, whatever its output enable.
- R11: rd_count shows count1 when rd_chan is 1 and count0 otherwise, without disturbing counting. A channel with run at 0 holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 8 | Register write data |
| rd_chan | input | 1 | Readback channel select |
| rd_count | output | 8 | Selected count value |
| presc_tick | input | 6 | One-cycle prescaler strobes, divide by 4, 16, 64, 256, 1024, 4096 |
| event_in | input | 1 | Asynchronous external event pin |
| pin_out | output | 2 | Toggle flop values gated by output enable |
| pin_en | output | 2 | Pin drive enables |
| sclk_out | output | 1 | Channel 0 toggle flop for the serial shift clock |
| irq_pulse | output | 2 | One-cycle interrupt requests per channel |

## Verification
The bench aims at a modulo of zero, which a design that only compares after incrementing would miss, letting the count run a full 256 steps. It runs long enough in 16-bit mode to cross a low-byte rollover. A design that matched on the low byte alone would pulse every few advances, and one that cleared only one byte would restart at a wrong value. It checks the chained clock of channel 1, which must advance only on rising toggles and not on every match. It also checks starts issued in cascade mode, which must clear the high byte too.

// File: rtl/tmr_pkg.sv
// Shared register map and control layout for the timer pair.
// Assumes an 8-bit or wider write data bus.
package tmr_pkg;
    localparam int ADDR_W      = 3;
    localparam logic [ADDR_W-1:0] A_MOD0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_MOD1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTL0 = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTL1 = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd4;
    localparam int SEL_W       = 3;
    localparam int B_RUN       = 3;
    localparam int B_START     = 4;
    localparam int B_OE        = 5;
    localparam int B_CASC      = 0;
    localparam int NCH         = 2;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             run;
        logic             oe;
    } tmr_ctl_t;
endpackage

// File: rtl/tmr_evsync.sv
// Synchronizes the asynchronous event pin and emits a one-cycle pulse
// on each rising edge. Assumes the pin stays at each level for at least
// two clock cycles so that no edge is lost.
module tmr_evsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    // Shift the pin through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_srcsel.sv
// Clock source selector for one channel. CH picks the tap set:
// channel 0 maps codes 1..5 to taps 0..4, and channel 1 maps code 1 to
// the chained input and codes 2..6 to taps 0,2,3,4,5. Code 0 is the
// event edge. Any other code selects nothing. Assumes NTAP >= 6.
module tmr_srcsel #(
    parameter int CH    = 0,
    parameter int NTAP  = 6,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [NTAP-1:0]  tick,
    input  logic             ev,
    input  logic             chain,
    output logic             src
);
    generate
        if (CH == 0) begin : g_ch0
            // Low channel: event edge or one of the five fastest taps.
            always_comb begin
                unique case (sel)
                    3'd0:    src = ev;
                    3'd1:    src = tick[0];
                    3'd2:    src = tick[1];
                    3'd3:    src = tick[2];
                    3'd4:    src = tick[3];
                    3'd5:    src = tick[4];
                    default: src = 1'b0;
                endcase
            end
            logic unused_chain;
            assign unused_chain = chain ^ (|tick[NTAP-1:5]);
        end else begin : g_ch1
            // High channel: event edge, chained output, or five slower taps.
            always_comb begin
                unique case (sel)
                    3'd0:    src = ev;
                    3'd1:    src = chain;
                    3'd2:    src = tick[0];
                    3'd3:    src = tick[2];
                    3'd4:    src = tick[3];
                    3'd5:    src = tick[4];
                    3'd6:    src = tick[5];
                    default: src = 1'b0;
                endcase
            end
            logic unused_tick;
            assign unused_tick = tick[1] ^ (|tick[NTAP-1:5]);
        end
    endgenerate
endmodule

// File: rtl/tmr_chan.sv
// One counter byte with its equality compare, toggle flop and interrupt
// pulse. The parent decides per cycle whether to step or wrap, so this
// slice serves both the 8-bit and the cascaded arrangement.
module tmr_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         step,
    input  logic         wrap,
    input  logic         hit,
    input  logic [W-1:0] modulo,
    output logic [W-1:0] count,
    output logic         eq,
    output logic         tflop,
    output logic         irq
);
    assign eq = (count == modulo);

    // Count register: start clears, a match wraps, an advance increments.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (restart) count <= '0;
        else if (wrap)    count <= '0;
        else if (step)    count <= count + 1'b1;
    end

    // Toggle flop and registered interrupt pulse on each match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tflop <= 1'b0;
            irq   <= 1'b0;
        end else begin
            tflop <= tflop ^ hit;
            irq   <= hit;
        end
    end
endmodule

// File: rtl/tmr_pair.sv
// Two modulo timer/event counters with an optional 16-bit cascade.
// Prescaler strobes come from outside as one-cycle pulses. The event pin
// is asynchronous. Register writes take effect on the next cycle.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int W           = 8,
    parameter int NTAP        = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    input  logic              rd_chan,
    output logic [W-1:0]      rd_count,
    input  logic [NTAP-1:0]   presc_tick,
    input  logic              event_in,
    output logic [NCH-1:0]    pin_out,
    output logic [NCH-1:0]    pin_en,
    output logic              sclk_out,
    output logic [NCH-1:0]    irq_pulse
);
    tmr_ctl_t          ctl_q [NCH];
    logic [W-1:0]      mod_q [NCH];
    logic              casc_q;
    logic [W-1:0]      cnt   [NCH];
    logic [NCH-1:0]    eq_v, tflop_v, src_v, en_v;
    logic [NCH-1:0]    step_v, wrap_v, hit_v, start_v, restart_v;
    logic              ev_rise, rise0, wide_eq;
    logic              hit0, step0, wrap0, hit1, step1, wrap1;
    logic [W-1:0]      cnt0_w, cnt1_w;

    // Register file writes for modulo, control and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                mod_q[i] <= '0;
                ctl_q[i] <= '0;
            end
            casc_q <= 1'b0;
        end else if (reg_we) begin
            unique case (reg_addr)
                A_MOD0: mod_q[0] <= reg_wdata;
                A_MOD1: mod_q[1] <= reg_wdata;
                A_CTL0: ctl_q[0] <= '{sel: reg_wdata[SEL_W-1:0], run: reg_wdata[B_RUN], oe: reg_wdata[B_OE]};
                A_CTL1: ctl_q[1] <= '{sel: reg_wdata[SEL_W-1:0], run: reg_wdata[B_RUN], oe: reg_wdata[B_OE]};
                A_MODE: casc_q   <= reg_wdata[B_CASC];
                default: ;
            endcase
        end
    end

    // Start strobes decoded straight from the write port.
    assign start_v[0]   = reg_we && (reg_addr == A_CTL0) && reg_wdata[B_START];
    assign start_v[1]   = reg_we && (reg_addr == A_CTL1) && reg_wdata[B_START];
    assign restart_v[0] = start_v[0];
    assign restart_v[1] = start_v[1] | (casc_q & start_v[0]);

    tmr_evsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(event_in), .rise(ev_rise)
    );

    assign rise0 = hit0 & ~tflop_v[0];

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            tmr_srcsel #(.CH(c), .NTAP(NTAP), .SEL_W(SEL_W)) u_sel (
                .sel(ctl_q[c].sel), .tick(presc_tick), .ev(ev_rise),
                .chain((c == 1) ? rise0 : 1'b0), .src(src_v[c])
            );
            assign en_v[c] = ctl_q[c].run & src_v[c];

            tmr_chan #(.W(W)) u_chan (
                .clk(clk), .rst_n(rst_n), .restart(restart_v[c]),
                .step(step_v[c]), .wrap(wrap_v[c]), .hit(hit_v[c]),
                .modulo(mod_q[c]), .count(cnt[c]), .eq(eq_v[c]),
                .tflop(tflop_v[c]), .irq(irq_pulse[c])
            );
        end
    endgenerate

    // Channel 0 sequencing, shared with the cascaded 16-bit pair.
    always_comb begin
        wide_eq = eq_v[0] & eq_v[1];
        if (casc_q) begin
            hit0  = en_v[0] & wide_eq;
            step0 = en_v[0] & ~wide_eq;
        end else begin
            hit0  = en_v[0] & eq_v[0];
            step0 = en_v[0] & ~eq_v[0];
        end
        wrap0 = hit0;
    end

    // Channel 1 sequencing: own clock alone, or carry from the low byte.
    always_comb begin
        if (casc_q) begin
            hit1  = 1'b0;
            wrap1 = hit0;
            step1 = step0 & (cnt[0] == {W{1'b1}});
        end else begin
            hit1  = en_v[1] & eq_v[1];
            wrap1 = hit1;
            step1 = en_v[1] & ~eq_v[1];
        end
    end

    assign step_v = {step1, step0};
    assign wrap_v = {wrap1, wrap0};
    assign hit_v  = {hit1, hit0};

    assign cnt0_w   = cnt[0];
    assign cnt1_w   = cnt[1];
    assign rd_count = rd_chan ? cnt1_w : cnt0_w;
    assign sclk_out = tflop_v[0];
    assign pin_en   = {ctl_q[1].oe, ctl_q[0].oe};
    assign pin_out  = pin_en & tflop_v;
endmodule

// File: rtl/tmr_pair_chk.sv
// Protocol checks for tmr_pair, attached with bind. Observes ports and a
// few internal nets. Assumes the synchronous active-low reset of the top.
module tmr_pair_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   irq,
    input logic         sclk,
    input logic [1:0]   pin_out,
    input logic [1:0]   pin_en,
    input logic         tf1,
    input logic [W-1:0] cnt0,
    input logic [W-1:0] cnt1,
    input logic         casc,
    input logic         start0,
    input logic         start1
);
    assert_irq_flips0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> (sclk != $past(sclk)));
    assert_irq_flips1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> (tf1 != $past(tf1)));
    assert_irq_zero0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> (cnt0 == '0));
    assert_irq_zero1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> (cnt1 == '0));
    assert_casc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && $past(casc)) |-> !irq[1]);
    assert_pin_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_en[0] |-> (pin_out[0] == sclk));
    assert_start_clr0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start0 |=> (cnt0 == '0));
    assert_start_clr1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start1 || (start0 && casc)) |=> (cnt1 == '0));
endmodule

bind tmr_pair tmr_pair_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq_pulse), .sclk(sclk_out),
    .pin_out(pin_out), .pin_en(pin_en), .tf1(tflop_v[1]),
    .cnt0(cnt0_w), .cnt1(cnt1_w), .casc(casc_q),
    .start0(start_v[0]), .start1(start_v[1])
);

// File: tb/tb_tmr_pair.sv
`timescale 1ns/1ps
module tb_tmr_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       rd_chan = 1'b0;
    logic [7:0] rd_count;
    logic [5:0] presc_tick = '0;
    logic       event_in = 1'b0;
    logic [1:0] pin_out, pin_en, irq_pulse;
    logic       sclk_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    tmr_pair dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_chan(rd_chan), .rd_count(rd_count),
        .presc_tick(presc_tick), .event_in(event_in), .pin_out(pin_out),
        .pin_en(pin_en), .sclk_out(sclk_out), .irq_pulse(irq_pulse)
    );

    // Reference state derived from the requirements.
    logic [7:0] mc0, mc1, mm0, mm1;
    logic [5:0] mctl0, mctl1;
    logic       mcasc, mf0, mf1, ms1, ms2, ms3;
    logic [1:0] mirq;

    function automatic logic src0(logic [2:0] c, logic [5:0] t, logic e);
        case (c)
            3'd0: return e;
            3'd1: return t[0];
            3'd2: return t[1];
            3'd3: return t[2];
            3'd4: return t[3];
            3'd5: return t[4];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic src1(logic [2:0] c, logic [5:0] t, logic e, logic r);
        case (c)
            3'd0: return e;
            3'd1: return r;
            3'd2: return t[0];
            3'd3: return t[2];
            3'd4: return t[3];
            3'd5: return t[4];
            3'd6: return t[5];
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic ev, e0, e1, h0, h1, r0;
        logic [7:0] n0, n1;
        if (!rst_n) begin
            mc0 = 0; mc1 = 0; mm0 = 0; mm1 = 0; mctl0 = 0; mctl1 = 0;
            mcasc = 0; mf0 = 0; mf1 = 0; ms1 = 0; ms2 = 0; ms3 = 0; mirq = 0;
        end else begin
            ev = ms2 & ~ms3;
            ms3 = ms2; ms2 = ms1; ms1 = event_in;
            n0 = mc0; n1 = mc1; h0 = 0; h1 = 0;
            e0 = mctl0[3] & src0(mctl0[2:0], presc_tick, ev);
            if (mcasc) begin
                if (e0) begin
                    if (mc0 == mm0 && mc1 == mm1) begin n0 = 0; n1 = 0; h0 = 1; end
                    else {n1, n0} = {mc1, mc0} + 16'd1;
                end
            end else begin
                if (e0) begin
                    if (mc0 == mm0) begin n0 = 0; h0 = 1; end else n0 = mc0 + 1;
                end
                r0 = h0 & ~mf0;
                e1 = mctl1[3] & src1(mctl1[2:0], presc_tick, ev, r0);
                if (e1) begin
                    if (mc1 == mm1) begin n1 = 0; h1 = 1; end else n1 = mc1 + 1;
                end
            end
            if (reg_we && reg_addr == 3'd2 && reg_wdata[4]) begin n0 = 0; if (mcasc) n1 = 0; end
            if (reg_we && reg_addr == 3'd3 && reg_wdata[4]) n1 = 0;
            mf0 = mf0 ^ h0; mf1 = mf1 ^ h1; mirq = {h1, h0};
            mc0 = n0; mc1 = n1;
            if (reg_we) case (reg_addr)
                3'd0: mm0 = reg_wdata;
                3'd1: mm1 = reg_wdata;
                3'd2: mctl0 = reg_wdata[5:0];
                3'd3: mctl1 = reg_wdata[5:0];
                3'd4: mcasc = reg_wdata[0];
                default: ;
            endcase
        end
    end

    task automatic chk(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the reference (called at the falling edge).
    task automatic compare();
        logic [7:0] ec;
        logic [1:0] eo, ep;
        ec = rd_chan ? mc1 : mc0;
        ep = {mctl1[5], mctl0[5]};
        eo = ep & {mf1, mf0};
        chk(rd_count == ec, "rd_count (R11)", rd_count, ec);
        chk(irq_pulse == mirq, "irq_pulse (R2)", irq_pulse, mirq);
        chk(pin_out == eo, "pin_out (R8)", pin_out, eo);
        chk(pin_en == ep, "pin_en (R8)", pin_en, ep);
        chk(sclk_out == mf0, "sclk_out (R10)", sclk_out, mf0);
    endtask

    task automatic cyc(bit we, logic [2:0] a, logic [7:0] d, logic [5:0] t, logic e);
        @(negedge clk);
        compare();
        reg_we = we; reg_addr = a; reg_wdata = d; presc_tick = t; event_in = e;
        rd_chan = $urandom_range(0, 1);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        cyc(1, a, d, 6'd0, event_in);
    endtask

    // Random ticks and slow events, optional random writes to masked addresses.
    task automatic rnd_run(int n, logic [4:0] wmask);
        logic ev = event_in;
        for (int i = 0; i < n; i++) begin
            bit we = 0;
            logic [2:0] a = 3'($urandom_range(0, 4));
            logic [7:0] d;
            if (($urandom % 8) == 0) ev = ~ev;
            if (wmask[a] && ($urandom % 12) == 0) we = 1;
            d = (a < 2) ? 8'($urandom_range(0, 6)) : 8'($urandom_range(0, 63));
            cyc(we, a, d, 6'($urandom), ev);
        end
    endtask

    initial begin
        void'($urandom(32'h1A2B));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tag = "R1";
        @(negedge clk);
        chk(rd_count == 0 && irq_pulse == 0 && pin_out == 0 && pin_en == 0 && sclk_out == 0,
            "reset outputs (R1)", {rd_count, irq_pulse, pin_out, pin_en}, 0);
        // R6: modulo zero, channel 0 on tap 0 every cycle
        tag = "R6";
        wr(3'd0, 8'd0);
        wr(3'd2, 8'h29);
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 6'b000001, 0);
        @(negedge clk);
        chk(irq_pulse[0] == 1'b1, "irq every advance (R6)", irq_pulse[0], 1);
        // R3: every channel 0 clock code
        tag = "R3";
        for (int c = 0; c < 8; c++) begin
            wr(3'd0, 8'($urandom_range(0, 5)));
            wr(3'd2, 8'(8'h38 | c));
            rnd_run(40, 5'b00001);
        end
        // R4: every channel 1 clock code, channel 0 fast on tap 0
        tag = "R4";
        wr(3'd0, 8'd1);
        wr(3'd2, 8'h29);
        for (int c = 0; c < 8; c++) begin
            wr(3'd1, 8'($urandom_range(0, 4)));
            wr(3'd3, 8'(8'h38 | c));
            rnd_run(60, 5'b00010);
        end
        // R5: event-driven counting on both channels
        tag = "R5";
        wr(3'd2, 8'h38);
        wr(3'd3, 8'h38);
        rnd_run(200, 5'b00000);
        // R7: cascade across the low-byte rollover
        tag = "R7";
        wr(3'd0, 8'd3);
        wr(3'd1, 8'd2);
        wr(3'd4, 8'd1);
        wr(3'd2, 8'h39);
        wr(3'd3, 8'h3A);
        for (int i = 0; i < 1600; i++) cyc(0, 0, 0, 6'b000001, 0);
        rnd_run(300, 5'b00000);
        // R9: starts in cascade and in 8-bit mode
        tag = "R9";
        rnd_run(300, 5'b00100);
        wr(3'd4, 8'd0);
        rnd_run(400, 5'b01100);
        // R8 / R10: output enables toggled while running
        tag = "R8";
        rnd_run(400, 5'b01111);
        // R11 / R2: everything random, including run off and mode changes
        tag = "R11";
        rnd_run(3000, 5'b11111);
        tag = "R2";
        rnd_run(2000, 5'b11111);
        @(negedge clk);
        compare();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired in %s", tag);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule